// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block schedules load tests of a backup battery and keeps a latched warning when the battery is weak. While the external supply is valid, it switches a test load onto the battery for a short window of whole seconds. During that window it watches a digital comparator flag that reports "battery below trip". At the close of the window it turns what it saw into a verdict on the warning. The analog comparator, the load resistor and the battery are outside the block. The block only drives the load-enable line and an open-drain style pull-low enable for the warning pin.

Every return of the supply triggers a test, and that test may either set or clear the warning. Tests that come from the long periodic timer can only set the warning; they never release it. A supply failure halts all scheduling. It releases the load in the same cycle and leaves the warning as it was. After the supply returns, the periodic timer counts again from the start of the power-up test. The interval and the window length are counted in one-second ticks and are parameters, so a bench can shorten them.

Top module: `batt_health_mon`

## Requirements
- R1: After synchronous reset, with the supply not valid, `test_load_en` and `warn_pull_low` are both 0.
- R2: The supply is valid when `power_good` is 1 and `supply_fail` is 0. At the first clock edge where the supply becomes valid, a power-up test starts and `test_load_en` reads 1 in the following cycle.
- R3: A test keeps `test_load_en` at 1 until the clock edge that samples the TEST_SECS-th `sec_tick` of the test, then drops it.
- R4: `batt_low` is 1 for "below trip" and passes through SYNC_STAGES flip-flops. If any synchronized sample taken during a test is 1, `warn_pull_low` becomes 1 at the edge that ends the window.
- R5: A periodic test that sees no low sample leaves an active warning at 1.
- R6: A power-up test that sees no low sample clears `warn_pull_low` to 0 at the end of its window.
- R7: While the supply stays valid, a periodic test starts at the edge that samples the INTERVAL_SECS-th `sec_tick` counted from the start of the previous test.
- R8: When the supply becomes invalid during a test, `test_load_en` falls in the same cycle, without waiting for a clock edge. The test is abandoned with no verdict, and `warn_pull_low` keeps its value.
- R9: While the supply is invalid, no test starts and ticks are not counted. After recovery, the periodic timer restarts from the start of the power-up test.
- R10: `test_load_en` is never 1 while the supply is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| power_good | input | 1 | Supervisor reports supply in tolerance |
| supply_fail | input | 1 | Supply failure in progress |
| batt_low | input | 1 | Asynchronous comparator flag, 1 = battery below trip |
| test_load_en | output | 1 | Connects the test load to the battery |
| warn_pull_low | output | 1 | Enables the open-drain pull-down of the warning pin |

## Verification
The assertions assume that `sec_tick` is a single-cycle pulse and that `power_good` and `supply_fail` are already synchronous to `clk`. They also assume TEST_SECS is smaller than INTERVAL_SECS, so that no periodic deadline can fall inside a window. The stimulus generates ticks from a free-running divider and changes the supply inputs only just after a clock edge. Only `batt_low` changes at arbitrary points relative to a test. The stimulus covers power-up tests that pass and that fail, periodic tests that pass and that fail, and supply loss both inside a window and between tests.

// File: rtl/batt_mon_pkg.sv
// Shared definitions for the battery health monitor.
package batt_mon_pkg;
    // Controller phases: no supply, test window open, waiting for next test.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_TEST = 2'd1,
        ST_IDLE = 2'd2
    } bm_state_t;
endpackage

// File: rtl/batt_flag_sync.sv
// batt_flag_sync: brings an asynchronous single-bit flag into the clk domain.
// Assumes: the flag is quasi-static compared to STAGES clock periods.
module batt_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int NS = (STAGES < 2) ? 2 : STAGES;

    logic [NS-1:0] chain_q;

    // Shift the raw flag through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[NS-2:0], din};
    end

    assign dout = chain_q[NS-1];
endmodule

// File: rtl/batt_tick_counter.sv
// batt_tick_counter: counts advance pulses modulo LIMIT and flags the final count.
// Assumes: clear has priority over advance; LIMIT >= 1.
module batt_tick_counter #(
    parameter int LIMIT = 86400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic at_last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks, wrapping after the final value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (adv)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/batt_test_ctrl.sv
// batt_test_ctrl: sequences power-up and periodic battery tests and holds the warning.
// Assumes: sec_tick is a one-cycle pulse; supply inputs are synchronous to clk;
// the window is shorter than the interval.
module batt_test_ctrl
    import batt_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic power_good,
    input  logic supply_fail,
    input  logic low_s,
    input  logic win_last,
    input  logic intv_last,
    output logic win_clr,
    output logic win_adv,
    output logic intv_clr,
    output logic intv_adv,
    output logic test_load_en,
    output logic warn_pull_low
);
    bm_state_t state_q;
    logic      pu_test_q;
    logic      fail_seen_q;
    logic      warn_q;
    logic      supply_ok;
    logic      start_pu;
    logic      start_per;
    logic      win_done;
    logic      verdict;

    assign supply_ok = power_good && !supply_fail;
    assign start_pu  = (state_q == ST_OFF) && supply_ok;
    assign start_per = (state_q == ST_IDLE) && supply_ok && sec_tick && intv_last;
    assign win_done  = (state_q == ST_TEST) && supply_ok && sec_tick && win_last;
    assign verdict   = fail_seen_q || low_s;

    assign win_clr  = (state_q != ST_TEST);
    assign win_adv  = (state_q == ST_TEST) && sec_tick;
    assign intv_clr = (state_q == ST_OFF) || start_per;
    assign intv_adv = sec_tick;

    // Phase sequencing: supply loss dominates, then test start and window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            pu_test_q <= 1'b0;
        end else if (!supply_ok) begin
            state_q   <= ST_OFF;
        end else if (start_pu) begin
            state_q   <= ST_TEST;
            pu_test_q <= 1'b1;
        end else if (start_per) begin
            state_q   <= ST_TEST;
            pu_test_q <= 1'b0;
        end else if (win_done) begin
            state_q   <= ST_IDLE;
        end
    end

    // Accumulate any low-battery sample seen inside the open window.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_TEST) fail_seen_q <= 1'b0;
        else                               fail_seen_q <= fail_seen_q || low_s;
    end

    // Apply the verdict: power-up tests overwrite, periodic tests only set.
    always_ff @(posedge clk) begin
        if (!rst_n)          warn_q <= 1'b0;
        else if (win_done)   warn_q <= pu_test_q ? verdict : (warn_q || verdict);
    end

    assign test_load_en  = (state_q == ST_TEST) && supply_ok;
    assign warn_pull_low = warn_q;

    // Warning never moves while the supply is invalid.
    assert_warn_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> $stable(warn_q));

    // A supply return always opens a power-up test.
    assert_pu_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pu |=> (state_q == ST_TEST) && pu_test_q);

    // A low sample at the final tick forces the warning on.
    assert_fail_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && low_s) |=> warn_q);

    // Outside a power-up test the warning is never released.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_q && !pu_test_q && supply_ok && !start_pu) |=> warn_q);

    // The window ends on its last tick.
    assert_window_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> (state_q == ST_IDLE));
endmodule

// File: rtl/batt_health_mon.sv
// batt_health_mon: top level of the periodic battery health monitor.
// Assumes: sec_tick is a single-cycle pulse at 1 Hz, TEST_SECS < INTERVAL_SECS.
module batt_health_mon #(
    parameter int INTERVAL_SECS = 86400,
    parameter int TEST_SECS     = 1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic power_good,
    input  logic supply_fail,
    input  logic batt_low,
    output logic test_load_en,
    output logic warn_pull_low
);
    logic low_s;
    logic win_last;
    logic intv_last;
    logic win_clr;
    logic win_adv;
    logic intv_clr;
    logic intv_adv;

    batt_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(batt_low), .dout(low_s)
    );

    batt_tick_counter #(.LIMIT(TEST_SECS)) u_win_cnt (
        .clk(clk), .rst_n(rst_n), .clr(win_clr), .adv(win_adv), .at_last(win_last)
    );

    batt_tick_counter #(.LIMIT(INTERVAL_SECS)) u_intv_cnt (
        .clk(clk), .rst_n(rst_n), .clr(intv_clr), .adv(intv_adv), .at_last(intv_last)
    );

    batt_test_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .power_good(power_good), .supply_fail(supply_fail), .low_s(low_s),
        .win_last(win_last), .intv_last(intv_last),
        .win_clr(win_clr), .win_adv(win_adv),
        .intv_clr(intv_clr), .intv_adv(intv_adv),
        .test_load_en(test_load_en), .warn_pull_low(warn_pull_low)
    );
endmodule

// File: tb/batt_health_mon_tb_top.sv
module batt_health_mon_tb_top;
    localparam int INTV = 20;
    localparam int WIN  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic power_good = 1'b0;
    logic supply_fail = 1'b0;
    logic batt_low = 1'b0;
    logic test_load_en;
    logic warn_pull_low;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    batt_health_mon #(.INTERVAL_SECS(INTV), .TEST_SECS(WIN), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .power_good(power_good),
        .supply_fail(supply_fail), .batt_low(batt_low),
        .test_load_en(test_load_en), .warn_pull_low(warn_pull_low)
    );

    // one-second tick: one cycle in four
    always @(posedge clk) begin
        cyc <= cyc + 1;
        sec_tick <= ((cyc % 4) == 3);
    end

    // behavioural reference: 0 off, 1 testing, 2 waiting
    int  m_st = 0;
    int  m_win = 0;
    int  m_intv = 0;
    bit  m_fail = 0, m_pu = 0, m_warn = 0;
    bit  m_s1 = 0, m_s2 = 0;

    always @(posedge clk) begin
        bit sok, low;
        sok = power_good && !supply_fail;
        low = m_s2;
        m_s2 = m_s1;
        m_s1 = batt_low;
        if (!rst_n) begin
            m_st = 0; m_pu = 0; m_warn = 0; m_s1 = 0; m_s2 = 0;
        end else if (!sok) begin
            m_st = 0;
        end else if (m_st == 0) begin
            m_st = 1; m_pu = 1; m_win = 0; m_intv = 0; m_fail = 0;
        end else if (m_st == 1) begin
            m_fail = m_fail | low;
            if (sec_tick) begin
                m_intv++;
                if (m_win == WIN - 1) begin
                    m_warn = m_pu ? m_fail : (m_warn | m_fail);
                    m_st = 2;
                end else m_win++;
            end
        end else if (sec_tick) begin
            if (m_intv == INTV - 1) begin
                m_st = 1; m_pu = 0; m_intv = 0; m_win = 0; m_fail = 0;
            end else m_intv++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        bit exp_load;
        if (rst_n && !done) begin
            exp_load = (m_st == 1) && power_good && !supply_fail;
            check(test_load_en === exp_load, "R3/R7/R9 load vs model", test_load_en, exp_load);
            check(warn_pull_low === m_warn, "R4/R5/R6 warn vs model", warn_pull_low, m_warn);
            if (!(power_good && !supply_fail))
                check(test_load_en === 1'b0, "R10", test_load_en, 0);
        end
    end

    task automatic after_edge();
        @(posedge clk); #1;
    endtask

    task automatic wait_load(input logic val);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (test_load_en === val) return;
        end
        check(1'b0, "wait_load timeout", test_load_en, val);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) after_edge();
        rst_n = 1'b1;
        after_edge();
        check(test_load_en === 1'b0, "R1 load", test_load_en, 0);
        check(warn_pull_low === 1'b0, "R1 warn", warn_pull_low, 0);

        // R2: first power-up, good battery
        power_good = 1'b1;
        @(posedge clk); @(negedge clk);
        check(test_load_en === 1'b1, "R2 load after power-up", test_load_en, 1);
        wait_load(1'b0);
        check(warn_pull_low === 1'b0, "R6 good power-up test", warn_pull_low, 0);

        // R4/R7: periodic test with low battery
        wait_load(1'b1);
        batt_low = 1'b1;
        wait_load(1'b0);
        batt_low = 1'b0;
        check(warn_pull_low === 1'b1, "R4 periodic fail sets warn", warn_pull_low, 1);

        // R5: periodic pass keeps warning
        wait_load(1'b1);
        wait_load(1'b0);
        check(warn_pull_low === 1'b1, "R5 sticky warn", warn_pull_low, 1);

        // R8: supply failure in the middle of a test
        wait_load(1'b1);
        @(posedge clk); #1;
        supply_fail = 1'b1;
        #1;
        check(test_load_en === 1'b0, "R8 load released at once", test_load_en, 0);
        for (int i = 0; i < 200; i++) after_edge();
        check(warn_pull_low === 1'b1, "R8 warn unchanged", warn_pull_low, 1);
        check(test_load_en === 1'b0, "R9 no test during failure", test_load_en, 0);

        // R6: recovery with a good battery clears the warning
        supply_fail = 1'b0;
        @(posedge clk); @(negedge clk);
        check(test_load_en === 1'b1, "R9 power-up test after recovery", test_load_en, 1);
        wait_load(1'b0);
        check(warn_pull_low === 1'b0, "R6 power-up pass clears", warn_pull_low, 0);

        // R4: power-up test that fails, then abort a periodic test
        after_edge();
        power_good = 1'b0;
        for (int i = 0; i < 10; i++) after_edge();
        batt_low = 1'b1;
        power_good = 1'b1;
        wait_load(1'b1);
        wait_load(1'b0);
        batt_low = 1'b0;
        check(warn_pull_low === 1'b1, "R4 power-up fail sets", warn_pull_low, 1);
        wait_load(1'b1);
        after_edge();
        power_good = 1'b0;
        for (int i = 0; i < 20; i++) after_edge();
        check(warn_pull_low === 1'b1, "R8 abort keeps warn", warn_pull_low, 1);
        power_good = 1'b1;
        for (int i = 0; i < 150; i++) after_edge();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule